// File: doc/BRIEF.md
# Video Field/Line Trigger Counter

This block fires a single-cycle trigger on one chosen line inside one chosen field of an interlaced video signal. A host supplies an 11-bit delay word and a field-select bit. The delay word is the two's complement of the number of line clocks between the field pulse and the wanted line. When a field pulse arrives for the selected field, the counter is loaded from the delay word and the line clock is held off for that cycle. After that, every line-clock strobe advances the counter. The strobe that carries the counter out of its top value raises the trigger and shuts the clock gate. The gate stays shut until the next matching field pulse, so the sequence runs once per frame.

Sync separation happens upstream, and the host chooses which field holds the wanted line. Both inputs arrive here as single-cycle strobes in the system clock domain. The delay word and the select bit are sampled only when a preset happens. A host can therefore write new values at any time without disturbing a count already in progress.

Top module: `field_line_trigger`

## Requirements
- R1: A synchronous active-high reset clears the trigger and closes the clock gate. After reset, line-clock strobes produce no trigger until a matching field pulse has arrived. A reset in the middle of a count also abandons that count.
- R2: A field pulse whose identity matches the select presets the counter from `delayIn` and opens the gate. The trigger then fires after exactly 2048 − `delayIn` line-clock strobes.
- R3: Field identity encoding: 0 is field 1 and 1 is field 2. A field pulse whose identity differs from `fieldSel` neither presets the counter nor opens the gate. This holds both when the block is idle and when a count is in progress.
- R4: A line-clock strobe in the same cycle as a matching field pulse is not counted.
- R5: The trigger is high for exactly one system-clock cycle per preset. Further line-clock strobes after the trigger produce nothing until the next matching field pulse.
- R6: A delay of 0x7FF triggers on the first counted strobe. A delay of 0x000 triggers on the 2048th strobe.
- R7: Changing `delayIn` or `fieldSel` during a count does not change when the running count ends.
- R8: A matching field pulse during a count restarts the count from the new preset.
- R9: The trigger is asserted in the system-clock cycle right after the line-clock strobe that causes the carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lineTick | input | 1 | One-cycle strobe per video line |
| fieldPulse | input | 1 | One-cycle strobe at the start of each field |
| fieldId | input | 1 | Identity of the field starting now (0 = field 1, 1 = field 2) |
| fieldSel | input | 1 | Field in which to trigger (0 = field 1, 1 = field 2) |
| delayIn | input | 11 | Two's-complement line delay, loaded at preset |
| trigger | output | 1 | One-cycle trigger pulse |

## Verification
The hardest case to reach from the ports is a line-clock strobe that lands in the same cycle as a matching field pulse. A mistake there shifts the trigger by only one line, and in normal operation the two strobes rarely coincide. The stimulus forces the coincidence on purpose and then checks the exact cycle of the trigger. Any early trigger shows up as an unexpected item at the scoreboard. The 2048-strobe wrap and mid-count restarts are driven the same way: the trigger cycle is predicted from the strobe count alone.

// File: rtl/field_trig_pkg.sv
package field_trig_pkg;
  // Strobes issued by control to the count datapath each cycle
  typedef struct packed {
    logic preset;   // load counter from delay word
    logic advance;  // count one line clock
  } trigStrobes_t;
endpackage

// File: rtl/field_trig_ctl.sv
module field_trig_ctl
  import field_trig_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         lineTick,
  input  logic         fieldPulse,
  input  logic         fieldId,
  input  logic         fieldSel,
  input  logic         carry,
  output trigStrobes_t strb,
  output logic         trigger
);
  logic gateOpen;
  logic presetHit;

  // A preset blocks the line clock in its own cycle
  assign presetHit   = fieldPulse && (fieldId == fieldSel);
  assign strb.preset  = presetHit;
  assign strb.advance = gateOpen && lineTick && !presetHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      gateOpen <= 1'b0;
      trigger  <= 1'b0;
    end else begin
      trigger <= carry;
      if (presetHit)
        gateOpen <= 1'b1;
      else if (carry)
        gateOpen <= 1'b0;
    end
  end
endmodule

// File: rtl/field_trig_dp.sv
module field_trig_dp
  import field_trig_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  trigStrobes_t     strb,
  input  logic [CNT_W-1:0] delayIn,
  output logic             carry
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count;

  assign carry = strb.advance && (count == TOP);

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (strb.preset)
      count <= delayIn;
    else if (strb.advance)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/field_line_trigger.sv
module field_line_trigger
  import field_trig_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lineTick,
  input  logic             fieldPulse,
  input  logic             fieldId,
  input  logic             fieldSel,
  input  logic [CNT_W-1:0] delayIn,
  output logic             trigger
);
  trigStrobes_t strb;
  logic         carry;

  field_trig_ctl i_ctl (
    .clk(clk), .rst(rst), .lineTick(lineTick), .fieldPulse(fieldPulse),
    .fieldId(fieldId), .fieldSel(fieldSel), .carry(carry),
    .strb(strb), .trigger(trigger)
  );

  field_trig_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .delayIn(delayIn), .carry(carry)
  );
endmodule

// File: rtl/field_trig_chk.sv
module field_trig_chk (
  input logic clk,
  input logic rst,
  input logic lineTick,
  input logic fieldPulse,
  input logic fieldId,
  input logic fieldSel,
  input logic trigger
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !trigger);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    trigger |=> !trigger);

  // R9
  follows_tick_chk: assert property (@(posedge clk) disable iff (rst)
    trigger |-> $past(lineTick));

  // R4
  preset_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (fieldPulse && (fieldId == fieldSel)) |=> !trigger);
endmodule

bind field_line_trigger field_trig_chk i_chk (
  .clk(clk), .rst(rst), .lineTick(lineTick), .fieldPulse(fieldPulse),
  .fieldId(fieldId), .fieldSel(fieldSel), .trigger(trigger)
);

// File: tb/test_field_line_trigger.sv
module test_field_line_trigger;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lineTick = 1'b0;
  logic        fieldPulse = 1'b0;
  logic        fieldId = 1'b0;
  logic        fieldSel = 1'b0;
  logic [10:0] delayIn = '0;
  logic        trigger;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int    expCyc[$];
  string expTag[$];
  logic  prevTrig = 1'b0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  field_line_trigger i_field_line_trigger (
    .clk(clk), .rst(rst), .lineTick(lineTick), .fieldPulse(fieldPulse),
    .fieldId(fieldId), .fieldSel(fieldSel), .delayIn(delayIn),
    .trigger(trigger)
  );

  // Monitor: pop expected trigger cycles as pulses appear
  always @(negedge clk) begin
    if (!rst) begin
      if (prevTrig) begin
        checks++;
        if (trigger) begin
          errors++;
          $display("FAIL R5 trigger wider than one cycle: actual=1 expected=0");
        end
      end
      if (trigger) begin
        checks++;
        if (expCyc.size() == 0) begin
          errors++;
          $display("FAIL unexpected trigger at cycle %0d: actual=1 expected=0", cyc);
        end else begin
          int    e;
          string t;
          e = expCyc.pop_front();
          t = expTag.pop_front();
          if (e != cyc) begin
            errors++;
            $display("FAIL %s trigger cycle: actual=%0d expected=%0d", t, cyc, e);
          end
        end
      end
    end
    prevTrig = trigger;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic id, input logic withTick);
    fieldPulse = 1'b1; fieldId = id; lineTick = withTick;
    @(negedge clk);
    fieldPulse = 1'b0; lineTick = 1'b0;
    @(negedge clk);
  endtask

  // Driver: send n strobes, push expected trigger for the last one
  task automatic ticks(input int n, input logic expectLast, input string tag);
    for (int i = 0; i < n; i++) begin
      lineTick = 1'b1;
      if (expectLast && i == n - 1) begin
        expCyc.push_back(cyc + 1);
        expTag.push_back(tag);
      end
      @(negedge clk);
      lineTick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic drained(input string tag);
    idle(3);
    checks++;
    if (expCyc.size() != 0) begin
      errors++;
      $display("FAIL %s missing trigger: actual=%0d pending expected=0", tag, expCyc.size());
      expCyc.delete();
      expTag.delete();
    end
  endtask

  initial begin
    idle(4);
    checks++;  // R1 reset state
    if (trigger !== 1'b0) begin
      errors++;
      $display("FAIL R1 trigger during reset: actual=%b expected=0", trigger);
    end
    rst = 1'b0;
    idle(2);

    // R1: gate closed after reset
    ticks(5, 1'b0, "R1");
    drained("R1");

    // R2/R9: delay of 5 lines
    fieldSel = 1'b0; delayIn = 11'd2043;
    pulse(1'b0, 1'b0);
    ticks(5, 1'b1, "R2/R9");
    drained("R2");
    // R5: no more triggers after carry
    ticks(3, 1'b0, "R5");
    drained("R5");

    // R6: all ones and zero
    delayIn = 11'h7FF;
    pulse(1'b0, 1'b0);
    ticks(1, 1'b1, "R6_ones");
    drained("R6");
    delayIn = 11'h000;
    pulse(1'b0, 1'b0);
    ticks(2048, 1'b1, "R6_zero");
    drained("R6");

    // R3: non-selected field ignored when idle
    fieldSel = 1'b1; delayIn = 11'd2044;
    pulse(1'b0, 1'b0);
    ticks(4, 1'b0, "R3_idle");
    drained("R3");
    pulse(1'b1, 1'b0);
    ticks(4, 1'b1, "R3_field2");
    drained("R3");

    // R3: non-selected pulse mid-count does not restart
    pulse(1'b1, 1'b0);
    ticks(2, 1'b0, "R3");
    pulse(1'b0, 1'b0);
    ticks(2, 1'b1, "R3_midcount");
    drained("R3");

    // R4: strobe coinciding with preset is not counted
    delayIn = 11'd2045;
    pulse(1'b1, 1'b1);
    ticks(3, 1'b1, "R4");
    drained("R4");

    // R7: input changes mid-count have no effect
    delayIn = 11'd2042;
    pulse(1'b1, 1'b0);
    ticks(2, 1'b0, "R7");
    delayIn = 11'h7FF; fieldSel = 1'b0;
    ticks(4, 1'b1, "R7");
    drained("R7");

    // R8: matching pulse mid-count restarts
    fieldSel = 1'b1; delayIn = 11'd2044;
    pulse(1'b1, 1'b0);
    ticks(2, 1'b0, "R8");
    pulse(1'b1, 1'b0);
    ticks(4, 1'b1, "R8");
    drained("R8");

    // R1: reset mid-count abandons it
    delayIn = 11'd2046;
    pulse(1'b1, 1'b0);
    ticks(1, 1'b0, "R1");
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    ticks(3, 1'b0, "R1_midreset");
    drained("R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=%0d expected<150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule